// File: doc/BRIEF.md
# Grayscale PWM Channel Generator

This block turns a set of latched per-channel brightness words into on/off enables for a bank of constant-current channels. A shared grayscale counter advances once for every grayscale reference tick, and each channel is enabled while the counter is below that channel's brightness value. A channel therefore stays on for exactly as many ticks as its brightness word, out of a cycle of 2^GS_BITS ticks. With the default 12-bit words the cycle is 4096 ticks long.

A blanking input forces every enable off and returns the counter to zero. The counter does not wrap. When it reaches its maximum, every channel goes off and a cycle-complete flag rises. Both stay that way until blanking is pulsed again. The brightness inputs are used combinationally, so a value that changes mid-cycle takes effect in the same clock. Each channel's 6-bit current-trim code is passed straight to a per-channel scale output, so a trim change also acts at once. The grayscale reference arrives as a one-cycle tick qualified on the system clock.

Top module: `gs_pwm_gen`

## Requirements
- R1: After a synchronous reset the counter is zero. With blanking low and no tick, channel i is on exactly when its brightness is non-zero.
- R2: While `blank` is high, every bit of `ch_on` and `cycle_done` is 0 in that same cycle.
- R3: A clock edge with `blank` high clears the counter to zero, so the next cycle restarts from count 0.
- R4: With `blank` low, each clock edge with `gs_tick` high raises the counter by one. An edge without `gs_tick` leaves it unchanged.
- R5: With `blank` low and the counter below its maximum, `ch_on[i]` is 1 exactly when the counter is less than the brightness of channel i. A brightness of 0 keeps the channel off for the whole cycle.
- R6: The counter stops at 2^GS_BITS-1 and does not wrap. While it is held there with `blank` low, `cycle_done` is 1 and all channels are off.
- R7: A brightness word that changes mid-cycle alters `ch_on` in the same cycle, measured against the current count.
- R8: `ch_scale[i*TRIM_BITS +: TRIM_BITS]` equals the trim code of channel i in the same cycle, whatever the state of `blank`.
- R9: The brightness of channel i is read from `gs_words[i*GS_BITS +: GS_BITS]`, and its trim code from `trim_words[i*TRIM_BITS +: TRIM_BITS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gs_tick | input | 1 | One-cycle grayscale reference tick |
| blank | input | 1 | Blanking: outputs off, counter restart |
| gs_words | input | NUM_CH*GS_BITS | Packed brightness words, channel 0 in the low bits |
| trim_words | input | NUM_CH*TRIM_BITS | Packed trim codes, channel 0 in the low bits |
| ch_on | output | NUM_CH | Per-channel enables |
| ch_scale | output | NUM_CH*TRIM_BITS | Per-channel current-scale codes |
| cycle_done | output | 1 | Counter has saturated |

## Verification
Only the counter is a register. `ch_on`, `cycle_done` and `ch_scale` are combinational functions of the inputs and the current count. A change of `blank`, brightness or trim is therefore due in the same cycle, and a tick or a blanking edge shows in the count one clock edge later. The bench drives inputs on the falling edge and compares all outputs 1 ns later, against a count it advances itself on each rising edge. Every comparison therefore sees both the inputs just applied and the count left by the previous edge.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

    localparam int DEF_NUM_CH    = 16;
    localparam int DEF_GS_BITS   = 12;
    localparam int DEF_TRIM_BITS = 6;

    typedef enum logic [1:0] {
        PH_BLANKED  = 2'd0,
        PH_COUNTING = 2'd1,
        PH_DONE     = 2'd2
    } gs_phase_e;

    // Count at which the cycle ends for a given counter width.
    function automatic int unsigned gs_last(input int unsigned bits);
        return (32'd1 << bits) - 32'd1;
    endfunction

endpackage

// File: rtl/gs_cycle_counter.sv
module gs_cycle_counter
    import gs_pwm_pkg::*;
#(
    parameter int GS_BITS = DEF_GS_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gs_tick,
    input  logic               blank,
    output logic [GS_BITS-1:0] count,
    output logic               saturated
);
    localparam logic [GS_BITS-1:0] CNT_LAST    = GS_BITS'(gs_last(GS_BITS));
    localparam logic [GS_BITS-1:0] CNT_PENULT  = CNT_LAST - 1'b1;

    logic [GS_BITS-1:0] cnt_q;
    gs_phase_e          phase_q;

    always_ff @(posedge clk) begin
        if (rst || blank) begin
            cnt_q   <= '0;
            phase_q <= PH_BLANKED;
        end else if (phase_q != PH_DONE) begin
            if (gs_tick) begin
                cnt_q   <= cnt_q + 1'b1;
                phase_q <= (cnt_q == CNT_PENULT) ? PH_DONE : PH_COUNTING;
            end else if (phase_q == PH_BLANKED) begin
                phase_q <= PH_COUNTING;
            end
        end
    end

    assign count     = cnt_q;
    assign saturated = (phase_q == PH_DONE);

    // R3: a blanked edge restarts the count
    a_r3_blank_clears: assert property (@(posedge clk) disable iff (rst)
        blank |=> cnt_q == '0);
    // R4: one step per tick
    a_r4_tick_step: assert property (@(posedge clk) disable iff (rst)
        (!blank && gs_tick && phase_q != PH_DONE) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R4: no tick, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!blank && !gs_tick) |=> cnt_q == $past(cnt_q));
    // R6: saturation holds without wrapping
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!blank && phase_q == PH_DONE) |=> cnt_q == CNT_LAST);
    // R6: done phase only at the last count
    a_r6_done_at_last: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |-> cnt_q == CNT_LAST);

endmodule

// File: rtl/gs_channel.sv
module gs_channel
    import gs_pwm_pkg::*;
#(
    parameter int GS_BITS   = DEF_GS_BITS,
    parameter int TRIM_BITS = DEF_TRIM_BITS
) (
    input  logic [GS_BITS-1:0]   level,
    input  logic [GS_BITS-1:0]   count,
    input  logic                 allow,
    input  logic [TRIM_BITS-1:0] trim,
    output logic                 on,
    output logic [TRIM_BITS-1:0] scale
);
    always_comb begin
        on    = allow && (count < level);
        scale = trim;
    end

    // R5: a zero level never lights the channel
    always_comb begin
        if (level == '0) a_r5_zero_dark: assert (!on);
    end

endmodule

// File: rtl/gs_pwm_gen.sv
module gs_pwm_gen
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH    = DEF_NUM_CH,
    parameter int GS_BITS   = DEF_GS_BITS,
    parameter int TRIM_BITS = DEF_TRIM_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          gs_tick,
    input  logic                          blank,
    input  logic [NUM_CH*GS_BITS-1:0]     gs_words,
    input  logic [NUM_CH*TRIM_BITS-1:0]   trim_words,
    output logic [NUM_CH-1:0]             ch_on,
    output logic [NUM_CH*TRIM_BITS-1:0]   ch_scale,
    output logic                          cycle_done
);
    logic [GS_BITS-1:0] count;
    logic               saturated;
    logic               allow;

    gs_cycle_counter #(.GS_BITS(GS_BITS)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .gs_tick   (gs_tick),
        .blank     (blank),
        .count     (count),
        .saturated (saturated)
    );

    assign allow      = !blank && !saturated;
    assign cycle_done = !blank && saturated;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        gs_channel #(.GS_BITS(GS_BITS), .TRIM_BITS(TRIM_BITS)) u_ch (
            .level (gs_words[i*GS_BITS +: GS_BITS]),
            .count (count),
            .allow (allow),
            .trim  (trim_words[i*TRIM_BITS +: TRIM_BITS]),
            .on    (ch_on[i]),
            .scale (ch_scale[i*TRIM_BITS +: TRIM_BITS])
        );
    end

    // R2: blanking darkens everything
    a_r2_blank_dark: assert property (@(posedge clk) disable iff (rst)
        blank |-> (ch_on == '0 && !cycle_done));
    // R6: completed cycle keeps channels off
    a_r6_done_dark: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> ch_on == '0);

endmodule

// File: tb/gs_pwm_gen_test.sv
`timescale 1ns/1ps
module gs_pwm_gen_test;
    localparam int NCH  = 4;
    localparam int GB   = 4;
    localparam int TB   = 6;
    localparam int LAST = (1 << GB) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gs_tick = 1'b0;
    logic blank = 1'b1;
    logic [NCH*GB-1:0] gs_words = '0;
    logic [NCH*TB-1:0] trim_words = '0;
    logic [NCH-1:0]    ch_on;
    logic [NCH*TB-1:0] ch_scale;
    logic              cycle_done;

    int errors = 0;
    int checks = 0;
    int model_cnt = 0;
    int lvl [NCH];
    int trm [NCH];
    bit finished = 0;

    always #4 clk = ~clk;

    gs_pwm_gen #(.NUM_CH(NCH), .GS_BITS(GB), .TRIM_BITS(TB)) uut (
        .clk(clk), .rst(rst), .gs_tick(gs_tick), .blank(blank),
        .gs_words(gs_words), .trim_words(trim_words),
        .ch_on(ch_on), .ch_scale(ch_scale), .cycle_done(cycle_done)
    );

    // R9: channel i occupies field i of each packed bus
    task automatic pack();
        for (int i = 0; i < NCH; i++) begin
            gs_words[i*GB +: GB]   = GB'(lvl[i]);
            trim_words[i*TB +: TB] = TB'(trm[i]);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NCH; i++) begin
            logic exp_on;
            exp_on = !blank && (model_cnt < LAST) && (model_cnt < lvl[i]);
            checks++;
            if (ch_on[i] !== exp_on) begin
                errors++;
                $display("FAIL %s ch%0d on: got %b exp %b (cnt %0d lvl %0d)",
                         tag, i, ch_on[i], exp_on, model_cnt, lvl[i]);
            end
            checks++;
            if (ch_scale[i*TB +: TB] !== TB'(trm[i])) begin
                errors++;
                $display("FAIL R8 ch%0d scale: got %0d exp %0d", i,
                         ch_scale[i*TB +: TB], trm[i]);
            end
        end
        checks++;
        if (cycle_done !== (!blank && model_cnt == LAST)) begin
            errors++;
            $display("FAIL %s done: got %b exp %b (cnt %0d)", tag, cycle_done,
                     (!blank && model_cnt == LAST), model_cnt);
        end
    endtask

    task automatic cyc(input logic b, input logic t, input string tag);
        @(negedge clk);
        blank = b;
        gs_tick = t;
        pack();
        #1;
        check_all(b ? "R2" : tag);
        @(posedge clk);
        if (b) model_cnt = 0;
        else if (t && model_cnt < LAST) model_cnt++;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            lvl[i] = i * 5;
            trm[i] = 63 - i * 7;
        end
        pack();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_cnt = 0;
        // R1: idle count after reset, no tick yet
        cyc(1'b0, 1'b0, "R1");

        // R5 R6: sweep every level on every channel, full cycle plus saturation
        for (int k = 0; k <= LAST; k++) begin
            lvl[0] = k;
            lvl[1] = LAST - k;
            lvl[2] = (k * 5) % (LAST + 1);
            lvl[3] = (k + 8) % (LAST + 1);
            trm[k % NCH] = (k * 11) % 64;
            cyc(1'b1, 1'b0, "R3");
            for (int s = 0; s < LAST + 3; s++)
                cyc(1'b0, 1'b1, (model_cnt == LAST) ? "R6" : "R5");
        end

        // R4: sparse ticks, counter holds between them
        lvl[0] = 3; lvl[1] = 7; lvl[2] = 0; lvl[3] = 15;
        cyc(1'b1, 1'b0, "R3");
        for (int s = 0; s < 3 * (LAST + 2); s++)
            cyc(1'b0, (s % 3) == 0, "R4");

        // R7: change brightness while counting
        cyc(1'b1, 1'b0, "R3");
        for (int s = 0; s < 6; s++) cyc(1'b0, 1'b1, "R5");
        lvl[0] = 2; lvl[1] = 9; lvl[2] = 6; lvl[3] = 7;
        cyc(1'b0, 1'b0, "R7");
        lvl[2] = 12;
        cyc(1'b0, 1'b1, "R7");

        // R3: blank mid-cycle then restart from zero
        cyc(1'b1, 1'b1, "R3");
        cyc(1'b0, 1'b0, "R3");
        cyc(1'b0, 1'b1, "R3");

        // R8: trim changes while blanked and while counting
        trm[0] = 0; trm[1] = 63; trm[2] = 21; trm[3] = 42;
        cyc(1'b1, 1'b0, "R8");
        trm[3] = 1;
        cyc(1'b0, 1'b1, "R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule